// File: doc/BRIEF.md
# Capacitive Stage Proximity Tracker

This block watches the conversion results of one capacitance-sensing stage. It keeps a short moving average of the incoming samples and a slowly drifting ambient baseline. When the average moves far enough away from the baseline for long enough, it raises a proximity flag. While that flag is up, the baseline is frozen so that a nearby hand is not learned as the new ambient.

If the measurement stays well above the stored baseline for a programmed number of conversions while proximity is active, the block assumes the environment has really changed. It then reloads the baseline with the current sample and drops the flag.

Samples arrive on a valid/ready stream. The block never applies back-pressure: `smp_ready` is high out of reset and stays high, so every cycle with `smp_valid` high delivers one sample. A cycle with `smp_valid` low carries nothing and changes no state. Control fields are plain inputs and are meant to stay constant while samples flow.

Top module: `prox_tracker`

## Requirements
- R1: The first sample accepted after reset seeds the state. On the following cycle `ambient` and `fast_avg` both equal that sample. No detection takes place on that sample.
- R2: After the seed, `fast_avg` is the floor of the mean of the four most recent accepted samples. At the seed, all four window slots take the seed value.
- R3: The baseline tracks the input only when the sample differs from the last accepted slow-filter sample by more than `cfg_slow_lvl`. On such a sample, `ambient` becomes `ambient + floor((sample - ambient)/16)` and the sample becomes the new slow-filter reference.
- R4: The proximity test runs on every sample when `cfg_det_rate` is 0. Otherwise it runs once every `cfg_det_rate*4` accepted samples, counted from the seed. The flag never changes on a sample that is not tested, except through a reload (R8).
- R5: A test is "over" when |new average − ambient| > `cfg_prox_lvl`. The flag rises on the (N+1)-th consecutive over test, where N is `cfg_low_cnt` when `low_power`=1 and `cfg_full_cnt` when `low_power`=0.
- R6: The first test that is not over clears the flag and the consecutive-test count.
- R7: `cal_disable` equals `prox_flag`. While the flag is high, `ambient` does not change unless a reload occurs.
- R8: While the flag is high, each sample with sample > ambient + `cfg_recal_lvl` advances a timeout count, and any other sample clears it. On the L-th such consecutive sample, `ambient` is loaded with the sample and the flag clears. L is `cfg_low_recal` (6 bits) in low-power mode and `cfg_full_recal` (8 bits) in full-power mode. L = 0 disables the reload.
- R9: `smp_ready` is 1 whenever reset is released. Cycles with `smp_valid`=0 change no output.
- R10: During and right after reset, `prox_flag`, `cal_disable`, `ambient` and `fast_avg` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample present |
| smp_ready | output | 1 | Always 1; the block takes a sample every cycle |
| smp_data | input | 16 | Conversion result |
| low_power | input | 1 | 1 selects the low-power count and timeout fields |
| cfg_full_cnt | input | 4 | Debounce count, full-power mode |
| cfg_low_cnt | input | 4 | Debounce count, low-power mode |
| cfg_full_recal | input | 8 | Reload timeout in conversions, full-power mode |
| cfg_low_recal | input | 6 | Reload timeout in conversions, low-power mode |
| cfg_prox_lvl | input | 8 | Proximity detection level |
| cfg_recal_lvl | input | 8 | Level above ambient that feeds the reload timeout |
| cfg_det_rate | input | 6 | Test interval, in units of 4 samples (0 = every sample) |
| cfg_slow_lvl | input | 8 | Minimum step for the baseline to take a sample |
| prox_flag | output | 1 | Proximity detected |
| cal_disable | output | 1 | Baseline tracking suspended |
| ambient | output | 16 | Stored ambient baseline |
| fast_avg | output | 16 | Four-sample moving average |

## Verification
The embedded assertions check the following on every cycle:
- idle cycles leave the average, the baseline and the flag untouched;
- the flag moves only on tested samples or on a reload;
- a failed test always clears the flag;
- a baseline step lands between the old baseline and the sample;
- a seed or reload writes the sample into the baseline;
- the baseline stays frozen under proximity.

Only the bench's scenarios can show the following:
- the exact debounce length in each power mode;
- the test interval phase counted from the seed;
- the floor arithmetic of the average and the one-sixteenth step;
- the reload landing on exactly the L-th qualifying conversion.

// File: rtl/prox_pkg.sv
package prox_pkg;

  typedef enum logic {
    PWR_FULL = 1'b0,
    PWR_LOW  = 1'b1
  } pwr_mode_e;

  // Unsigned distance between two operands widened to 32 bits.
  function automatic logic [31:0] abs_gap(input logic [31:0] a, input logic [31:0] b);
    return (a >= b) ? (a - b) : (b - a);
  endfunction

endpackage

// File: rtl/prox_avg.sv
module prox_avg #(
  parameter int DW         = 16,
  parameter int LOG2_DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          seed,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] avg_next,
  output logic [DW-1:0] avg_q
);
  localparam int DEPTH = 1 << LOG2_DEPTH;
  localparam int SW    = DW + LOG2_DEPTH;

  logic [DW-1:0] win [DEPTH];
  logic [SW-1:0] sum;

  // Sum of the incoming sample and the DEPTH-1 newest stored samples.
  always_comb begin
    sum = SW'(din);
    for (int i = 0; i < DEPTH - 1; i++) sum = sum + SW'(win[i]);
  end

  assign avg_next = seed ? din : DW'(sum >> LOG2_DEPTH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) win[i] <= '0;
      avg_q <= '0;
    end else if (take) begin
      win[0] <= din;
      for (int i = 1; i < DEPTH; i++) win[i] <= seed ? din : win[i-1];
      avg_q <= avg_next;
    end
  end

  AST_AVG_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(avg_q)); // R9

endmodule

// File: rtl/prox_baseline.sv
module prox_baseline #(
  parameter int DW         = 16,
  parameter int SLOW_W     = 8,
  parameter int SLOW_SHIFT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              seed,
  input  logic              reload,
  input  logic              cal_en,
  input  logic [DW-1:0]     din,
  input  logic [SLOW_W-1:0] slow_lvl,
  output logic [DW-1:0]     amb_q
);
  import prox_pkg::*;

  logic [DW-1:0]      last_q;
  logic               accept;
  logic signed [DW:0] err, step, moved;

  assign accept = abs_gap(32'(din), 32'(last_q)) > 32'(slow_lvl);
  assign err    = $signed({1'b0, din}) - $signed({1'b0, amb_q});
  assign step   = err >>> SLOW_SHIFT;
  assign moved  = $signed({1'b0, amb_q}) + step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      amb_q  <= '0;
      last_q <= '0;
    end else if (seed || reload) begin
      amb_q  <= din;
      last_q <= din;
    end else if (take && cal_en && accept) begin
      last_q <= din;
      amb_q  <= moved[DW-1:0];
    end
  end

  AST_AMB_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(amb_q)); // R9

  AST_AMB_TOWARD: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !seed && !reload) |=>
      (($past(din) >= $past(amb_q)) ? (amb_q >= $past(amb_q) && amb_q <= $past(din))
                                    : (amb_q <= $past(amb_q) && amb_q >= $past(din)))); // R3

endmodule

// File: rtl/prox_detect.sv
module prox_detect #(
  parameter int DW         = 16,
  parameter int CNT_W      = 4,
  parameter int FP_RECAL_W = 8,
  parameter int LP_RECAL_W = 6,
  parameter int LVL_W      = 8,
  parameter int RATE_W     = 6,
  parameter int MULT_LOG2  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  take,
  input  prox_pkg::pwr_mode_e   mode,
  input  logic [DW-1:0]         avg_next,
  input  logic [DW-1:0]         amb_q,
  input  logic [DW-1:0]         din,
  input  logic [CNT_W-1:0]      full_cnt,
  input  logic [CNT_W-1:0]      low_cnt,
  input  logic [FP_RECAL_W-1:0] full_recal,
  input  logic [LP_RECAL_W-1:0] low_recal,
  input  logic [LVL_W-1:0]      prox_lvl,
  input  logic [LVL_W-1:0]      recal_lvl,
  input  logic [RATE_W-1:0]     det_rate,
  output logic                  prox_q,
  output logic                  reload
);
  import prox_pkg::*;

  localparam int RCW = RATE_W + MULT_LOG2;
  localparam int TW  = (FP_RECAL_W > LP_RECAL_W) ? FP_RECAL_W : LP_RECAL_W;
  localparam logic [RCW-1:0]   RC_ONE  = RCW'(1);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [TW:0]      T_ONE   = (TW+1)'(1);

  logic [RCW-1:0]   rcnt_q, interval;
  logic [CNT_W-1:0] run_q, run_next, dbn;
  logic [TW-1:0]    timer_q, timer_inc, limit;
  logic             eval, over, hi, prox_next;

  assign interval  = RCW'(det_rate) << MULT_LOG2;
  assign eval      = (interval == '0) || (rcnt_q >= interval - RC_ONE);
  assign over      = abs_gap(32'(avg_next), 32'(amb_q)) > 32'(prox_lvl);
  assign hi        = 32'(din) > (32'(amb_q) + 32'(recal_lvl));
  assign dbn       = (mode == PWR_LOW) ? low_cnt : full_cnt;
  assign limit     = (mode == PWR_LOW) ? TW'(low_recal) : TW'(full_recal);
  assign timer_inc = (timer_q == '1) ? timer_q : timer_q + TW'(1);

  assign reload = take && prox_q && hi && (limit != '0) &&
                  (({1'b0, timer_q} + T_ONE) == {1'b0, limit});

  always_comb begin
    prox_next = prox_q;
    run_next  = run_q;
    if (eval) begin
      if (over) begin
        prox_next = prox_q || (run_q >= dbn);
        run_next  = (run_q == '1) ? run_q : run_q + CNT_ONE;
      end else begin
        prox_next = 1'b0;
        run_next  = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prox_q  <= 1'b0;
      run_q   <= '0;
      timer_q <= '0;
      rcnt_q  <= '0;
    end else if (take) begin
      rcnt_q <= eval ? '0 : rcnt_q + RC_ONE;
      if (reload) begin
        prox_q  <= 1'b0;
        run_q   <= '0;
        timer_q <= '0;
      end else begin
        prox_q  <= prox_next;
        run_q   <= run_next;
        timer_q <= (prox_q && hi && prox_next) ? timer_inc : '0;
      end
    end
  end

  AST_FLAG_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(prox_q)); // R9

  AST_FLAG_UNTESTED: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !eval && !reload) |=> $stable(prox_q)); // R4

  AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (take && eval && !over) |=> !prox_q); // R6

  AST_RELOAD_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> !prox_q); // R8

endmodule

// File: rtl/prox_tracker.sv
module prox_tracker #(
  parameter int DW         = 16,
  parameter int CNT_W      = 4,
  parameter int FP_RECAL_W = 8,
  parameter int LP_RECAL_W = 6,
  parameter int LVL_W      = 8,
  parameter int RATE_W     = 6,
  parameter int MULT_LOG2  = 2,
  parameter int LOG2_AVG   = 2,
  parameter int SLOW_SHIFT = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  smp_valid,
  output logic                  smp_ready,
  input  logic [DW-1:0]         smp_data,
  input  logic                  low_power,
  input  logic [CNT_W-1:0]      cfg_full_cnt,
  input  logic [CNT_W-1:0]      cfg_low_cnt,
  input  logic [FP_RECAL_W-1:0] cfg_full_recal,
  input  logic [LP_RECAL_W-1:0] cfg_low_recal,
  input  logic [LVL_W-1:0]      cfg_prox_lvl,
  input  logic [LVL_W-1:0]      cfg_recal_lvl,
  input  logic [RATE_W-1:0]     cfg_det_rate,
  input  logic [LVL_W-1:0]      cfg_slow_lvl,
  output logic                  prox_flag,
  output logic                  cal_disable,
  output logic [DW-1:0]         ambient,
  output logic [DW-1:0]         fast_avg
);
  import prox_pkg::*;

  logic          primed_q, take, seed, armed_take, reload, prox;
  logic [DW-1:0] avg_next;
  pwr_mode_e     mode;

  assign smp_ready  = 1'b1;
  assign take       = smp_valid && smp_ready;
  assign seed       = take && !primed_q;
  assign armed_take = take && primed_q;
  assign mode       = low_power ? PWR_LOW : PWR_FULL;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    primed_q <= 1'b0;
    else if (take) primed_q <= 1'b1;
  end

  prox_avg #(.DW(DW), .LOG2_DEPTH(LOG2_AVG)) u_avg (
    .clk(clk), .rst_n(rst_n), .take(take), .seed(seed), .din(smp_data),
    .avg_next(avg_next), .avg_q(fast_avg)
  );

  prox_baseline #(.DW(DW), .SLOW_W(LVL_W), .SLOW_SHIFT(SLOW_SHIFT)) u_base (
    .clk(clk), .rst_n(rst_n), .take(take), .seed(seed), .reload(reload),
    .cal_en(!prox), .din(smp_data), .slow_lvl(cfg_slow_lvl), .amb_q(ambient)
  );

  prox_detect #(
    .DW(DW), .CNT_W(CNT_W), .FP_RECAL_W(FP_RECAL_W), .LP_RECAL_W(LP_RECAL_W),
    .LVL_W(LVL_W), .RATE_W(RATE_W), .MULT_LOG2(MULT_LOG2)
  ) u_det (
    .clk(clk), .rst_n(rst_n), .take(armed_take), .mode(mode),
    .avg_next(avg_next), .amb_q(ambient), .din(smp_data),
    .full_cnt(cfg_full_cnt), .low_cnt(cfg_low_cnt),
    .full_recal(cfg_full_recal), .low_recal(cfg_low_recal),
    .prox_lvl(cfg_prox_lvl), .recal_lvl(cfg_recal_lvl), .det_rate(cfg_det_rate),
    .prox_q(prox), .reload(reload)
  );

  assign prox_flag   = prox;
  assign cal_disable = prox;

  AST_SEED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    seed |=> (ambient == $past(smp_data) && fast_avg == $past(smp_data))); // R1

  AST_CAL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (prox_flag && !reload) |=> (ambient == $past(ambient))); // R7

  AST_RELOAD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (ambient == $past(smp_data))); // R8

endmodule

// File: tb/tb_prox_tracker.sv
module tb_prox_tracker;
  logic clk = 0, rst_n = 0;
  logic smp_valid = 0, smp_ready;
  logic [15:0] smp_data = 0;
  logic low_power = 0;
  logic [3:0] cfg_full_cnt = 2, cfg_low_cnt = 0;
  logic [7:0] cfg_full_recal = 5;
  logic [5:0] cfg_low_recal = 3;
  logic [7:0] cfg_prox_lvl = 50, cfg_recal_lvl = 30, cfg_slow_lvl = 20;
  logic [5:0] cfg_det_rate = 0;
  logic prox_flag, cal_disable;
  logic [15:0] ambient, fast_avg;

  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  prox_tracker dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_data(smp_data), .low_power(low_power),
    .cfg_full_cnt(cfg_full_cnt), .cfg_low_cnt(cfg_low_cnt),
    .cfg_full_recal(cfg_full_recal), .cfg_low_recal(cfg_low_recal),
    .cfg_prox_lvl(cfg_prox_lvl), .cfg_recal_lvl(cfg_recal_lvl),
    .cfg_det_rate(cfg_det_rate), .cfg_slow_lvl(cfg_slow_lvl),
    .prox_flag(prox_flag), .cal_disable(cal_disable),
    .ambient(ambient), .fast_avg(fast_avg)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int  win[$];
  int  m_amb, m_last, m_avg, m_run, m_timer, m_rcnt;
  bit  m_prox, m_primed;

  always @(posedge clk) begin
    if (!rst_n) begin
      win = {}; m_amb = 0; m_last = 0; m_avg = 0; m_run = 0; m_timer = 0;
      m_rcnt = 0; m_prox = 0; m_primed = 0;
    end else if (smp_valid) begin
      int d, s, navg, intv, dbn, lim, gap;
      bit ev, over, hi, np;
      d = smp_data;
      if (!m_primed) begin
        m_primed = 1; win = {d, d, d, d}; m_avg = d; m_amb = d; m_last = d;
      end else begin
        win.push_front(d); void'(win.pop_back());
        s = 0;
        foreach (win[i]) s += win[i];
        navg = s / 4;
        intv = cfg_det_rate * 4;
        ev   = (intv == 0) || (m_rcnt >= intv - 1);
        gap  = navg - m_amb; if (gap < 0) gap = -gap;
        over = gap > cfg_prox_lvl;
        hi   = d > m_amb + cfg_recal_lvl;
        dbn  = low_power ? cfg_low_cnt : cfg_full_cnt;
        lim  = low_power ? cfg_low_recal : cfg_full_recal;
        if (m_prox && hi && lim != 0 && m_timer + 1 == lim) begin
          m_amb = d; m_last = d; m_prox = 0; m_run = 0; m_timer = 0;
        end else begin
          np = m_prox;
          if (ev) begin
            if (over) begin
              if (m_run >= dbn) np = 1;
              if (m_run < 15) m_run++;
            end else begin
              m_run = 0; np = 0;
            end
          end
          if (!m_prox) begin
            gap = d - m_last; if (gap < 0) gap = -gap;
            if (gap > cfg_slow_lvl) begin
              m_last = d; m_amb = m_amb + ((d - m_amb) >>> 4);
            end
          end
          m_timer = (m_prox && hi && np) ? ((m_timer < 255) ? m_timer + 1 : 255) : 0;
          m_prox = np;
        end
        m_rcnt = ev ? 0 : m_rcnt + 1;
        m_avg = navg;
      end
    end
  end

  // Every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 fast_avg", fast_avg, m_avg);
      chk("R3 ambient", ambient, m_amb);
      chk("R4 R5 R6 prox_flag", prox_flag, m_prox);
      chk("R7 cal_disable", cal_disable, m_prox);
    end
  end

  task automatic send(input int d);
    smp_valid = 1; smp_data = d[15:0];
    @(negedge clk);
    smp_valid = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    int a0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10 prox_flag", prox_flag, 0);
    chk("R10 cal_disable", cal_disable, 0);
    chk("R10 ambient", ambient, 0);
    chk("R10 fast_avg", fast_avg, 0);
    chk("R9 smp_ready", smp_ready, 1);

    send(1000);
    chk("R1 ambient seed", ambient, 1000);
    chk("R1 fast_avg seed", fast_avg, 1000);

    smp_data = 5000;
    repeat (3) @(negedge clk);
    chk("R9 ambient idle", ambient, 1000);
    chk("R9 fast_avg idle", fast_avg, 1000);

    send(1010);
    chk("R3 small step ignored", ambient, 1000);
    chk("R2 avg floor", fast_avg, 1002);
    send(1160);
    chk("R3 one-sixteenth step", ambient, 1010);
    chk("R2 avg", fast_avg, 1042);

    for (int i = 0; i < 20 && !prox_flag; i++) send(1400);
    chk("R5 flag raised full power", prox_flag, 1);
    a0 = ambient;
    send(1400);
    chk("R7 ambient frozen", ambient, a0);
    chk("R7 cal_disable high", cal_disable, 1);
    for (int i = 0; i < 20 && prox_flag; i++) send(1400);
    chk("R8 reload value", ambient, 1400);
    chk("R8 flag dropped", prox_flag, 0);

    cfg_full_recal = 0;
    for (int i = 0; i < 20 && !prox_flag; i++) send(1600);
    chk("R5 flag raised again", prox_flag, 1);
    for (int i = 0; i < 8; i++) send(1600);
    chk("R8 timeout disabled", prox_flag, 1);
    for (int i = 0; i < 20 && prox_flag; i++) send(1400);
    chk("R6 flag cleared", prox_flag, 0);

    do_reset();
    low_power = 1; cfg_det_rate = 1; cfg_slow_lvl = 255; cfg_low_cnt = 0;
    send(1000);
    send(2000); send(2000); send(2000);
    chk("R4 untested samples", prox_flag, 0);
    send(2000);
    chk("R4 R5 flag on tested sample", prox_flag, 1);
    a0 = ambient;
    send(2000); send(2000);
    chk("R7 frozen low power", ambient, a0);
    send(2000);
    chk("R8 low power reload", ambient, 2000);
    chk("R8 low power flag", prox_flag, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule